// File: doc/BRIEF.md
# Quasi-Random Test Signal Generator

This block produces a quasi-random test bit stream for a line framer. A 20-stage linear feedback shift register, whose feedback taps give the maximum sequence length, produces the pattern. The output bit does not simply copy the last stage. It is forced high whenever a long run of zeros sits in the stages behind the last stage. This limits how many zeros in a row reach the line.

The framer raises the advance input for every payload bit position. While advance is low, for example during framing or data-link slots that the framer inserts itself, the register keeps its state. A synchronous load input presets any state, which lets a test start from a known point in the sequence. The whole register is visible as a state word. Both outputs are registered and always describe the same register contents.

Top module: `qrss_gen`

## Requirements
- R1: On an advance, the new stage 1 (state_o bit 0) equals the XOR of the old stage 17 (bit 16) and stage 20 (bit 19). Stage k is state_o bit k-1.
- R2: On an advance, each stage k from 2 to 20 takes the old value of stage k-1. The state changes on the clock edge that samples adv_i high.
- R3: With adv_i low and load_i low, state_o and bit_o keep their values.
- R4: bit_o equals stage 20 OR'd with the result of a zero check on stages 19 down to 6. The check is 1 when all of those stages hold 0. bit_o always refers to the state shown on state_o in the same cycle.
- R5: Synchronous reset (rst high) sets every stage to 1, so bit_o is 1 after reset.
- R6: load_i high loads seed_i on the next edge. A seed of all zeros is replaced by all ones. load_i takes priority over adv_i.
- R7: state_o is never all zeros, so the register cannot lock up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_i | input | 1 | Advance the sequence by one bit |
| load_i | input | 1 | Synchronous preset from seed_i |
| seed_i | input | 20 | Preset value, bit k-1 is stage k |
| bit_o | output | 1 | Quasi-random output bit after zero suppression |
| state_o | output | 20 | Current register contents |

## Verification
A wrong tap or a wrong shift direction makes state_o differ from the reference within one advance. A lost zero override only shows up in bit_o, and only once stages 19 to 6 are all zero. The bench therefore loads seeds that make the override matter in the very next cycle. A stall or priority fault shows up as state_o changing, or failing to change, on the edge that follows the adv_i or load_i stimulus. The bench compares state_o and bit_o against a behavioural model after every clock.

// File: rtl/qrss_pkg.sv
package qrss_pkg;
  // Default geometry of the quasi-random generator (stage numbers are 1-based)
  parameter int unsigned QRSS_STAGES  = 20;
  parameter int unsigned QRSS_TAP     = 17;
  parameter int unsigned QRSS_ZRUN_HI = 19;
  parameter int unsigned QRSS_ZRUN_LO = 6;
endpackage

// File: rtl/qrss_shift_reg.sv
module qrss_shift_reg #(
  parameter int unsigned WIDTH = qrss_pkg::QRSS_STAGES,
  parameter int unsigned TAP   = qrss_pkg::QRSS_TAP
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             load,
  input  logic [WIDTH-1:0] seed,
  output logic [WIDTH-1:0] state_q,
  output logic [WIDTH-1:0] state_d
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic [WIDTH-1:0] shifted;
  logic [WIDTH-1:0] seed_safe;

  assign shifted[0] = state_q[TAP-1] ^ state_q[WIDTH-1];
  for (genvar k = 1; k < WIDTH; k++) begin : g_stage
    assign shifted[k] = state_q[k-1];
  end

  assign seed_safe = (seed == '0) ? ALL_ONES : seed;

  always_comb begin
    state_d = state_q;
    if (load)     state_d = seed_safe;
    else if (adv) state_d = shifted;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ALL_ONES;
    else     state_q <= state_d;
  end

  AST_FEEDBACK: assert property (@(posedge clk) disable iff (rst)
    (adv && !load) |=> state_q[0] == ($past(state_q[TAP-1]) ^ $past(state_q[WIDTH-1]))); // R1
  AST_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (adv && !load) |=> state_q[WIDTH-1:1] == $past(state_q[WIDTH-2:0])); // R2
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!adv && !load) |=> $stable(state_q)); // R3
  AST_LOAD: assert property (@(posedge clk) disable iff (rst)
    (load && seed != '0) |=> state_q == $past(seed)); // R6
  AST_LOAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (load && seed == '0) |=> state_q == ALL_ONES); // R6
  AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (rst)
    state_q != '0); // R7
endmodule

// File: rtl/qrss_zero_force.sv
module qrss_zero_force #(
  parameter int unsigned WIDTH = qrss_pkg::QRSS_STAGES,
  parameter int unsigned HI    = qrss_pkg::QRSS_ZRUN_HI,
  parameter int unsigned LO    = qrss_pkg::QRSS_ZRUN_LO
) (
  input  logic [WIDTH-1:0] state,
  output logic             bit_out
);
  localparam int unsigned RUN = HI - LO + 1;

  logic [RUN-1:0] window;
  logic           run_zero;

  assign window   = state[HI-1:LO-1];
  assign run_zero = (window == '0);
  assign bit_out  = state[WIDTH-1] | run_zero;
endmodule

// File: rtl/qrss_gen.sv
module qrss_gen #(
  parameter int unsigned WIDTH   = qrss_pkg::QRSS_STAGES,
  parameter int unsigned TAP     = qrss_pkg::QRSS_TAP,
  parameter int unsigned ZRUN_HI = qrss_pkg::QRSS_ZRUN_HI,
  parameter int unsigned ZRUN_LO = qrss_pkg::QRSS_ZRUN_LO
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] seed_i,
  output logic             bit_o,
  output logic [WIDTH-1:0] state_o
);
  logic [WIDTH-1:0] st_q;
  logic [WIDTH-1:0] st_d;
  logic             bit_d;

  qrss_shift_reg #(.WIDTH(WIDTH), .TAP(TAP)) u_sr (
    .clk(clk), .rst(rst), .adv(adv_i), .load(load_i), .seed(seed_i),
    .state_q(st_q), .state_d(st_d)
  );

  // Output is computed from the next state so it lines up with state_o
  qrss_zero_force #(.WIDTH(WIDTH), .HI(ZRUN_HI), .LO(ZRUN_LO)) u_zf (
    .state(st_d), .bit_out(bit_d)
  );

  always_ff @(posedge clk) begin
    if (rst) bit_o <= 1'b1;
    else     bit_o <= bit_d;
  end

  assign state_o = st_q;

  AST_FORCE_ONE: assert property (@(posedge clk) disable iff (rst)
    (state_o[ZRUN_HI-1:ZRUN_LO-1] == '0) |-> bit_o); // R4
  AST_RAW_BIT: assert property (@(posedge clk) disable iff (rst)
    (state_o[ZRUN_HI-1:ZRUN_LO-1] != '0) |-> (bit_o == state_o[WIDTH-1])); // R4
  AST_HOLD_BIT: assert property (@(posedge clk) disable iff (rst)
    (!adv_i && !load_i) |=> $stable(bit_o)); // R3
endmodule

// File: tb/qrss_gen_test.sv
module qrss_gen_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        adv_i = 1'b0;
  logic        load_i = 1'b0;
  logic [19:0] seed_i = '0;
  logic        bit_o;
  logic [19:0] state_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [19:0] model;

  qrss_gen uut (
    .clk(clk), .rst(rst), .adv_i(adv_i), .load_i(load_i), .seed_i(seed_i),
    .bit_o(bit_o), .state_o(state_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic exp_bit(input logic [19:0] s);
    int zeros = 0;
    for (int k = 6; k <= 19; k++) if (s[k-1] == 1'b0) zeros++;
    return s[19] | (zeros == 14);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Apply one cycle of stimulus, update the model, compare after the edge
  task automatic step(input logic a, input logic l, input logic [19:0] sd, input string req);
    int fb;
    adv_i = a; load_i = l; seed_i = sd;
    @(posedge clk);
    if (l) model = (sd == 0) ? 20'hFFFFF : sd;
    else if (a) begin
      fb = model[16] ^ model[19];
      model = {model[18:0], 1'(fb)};
    end
    @(negedge clk);
    chk({req, " state"}, 32'(state_o), 32'(model));
    chk({req, " bit"},   32'(bit_o),   32'(exp_bit(model)));
    chk("R7 nonzero", 32'(state_o != 0), 32'd1);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    model = 20'hFFFFF;
    chk("R5 reset state", 32'(state_o), 32'hFFFFF);
    chk("R5 reset bit", 32'(bit_o), 32'd1);

    // R1 R2: continuous advance
    for (int i = 0; i < 3000; i++) step(1'b1, 1'b0, '0, "R1 R2 advance");
    // R3: hold with adv low, mixed gating
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, 20'h12345, "R3 hold");
    for (int i = 0; i < 4000; i++) step(1'($urandom_range(0, 1)), 1'b0, '0, "R2 R3 gated");

    // R4: override active, raw stage 20 is 0
    step(1'b0, 1'b1, 20'h0001F, "R6 load");
    chk("R4 forced one", 32'(bit_o), 32'd1);
    // R4: stage 6 set, so no override, raw 0
    step(1'b0, 1'b1, 20'h00020, "R6 load");
    chk("R4 raw zero", 32'(bit_o), 32'd0);
    // R4: stage 19 set only, no override
    step(1'b0, 1'b1, 20'h40000, "R6 load");
    chk("R4 raw zero s19", 32'(bit_o), 32'd0);
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0, '0, "R4 walk");

    // R6: zero seed replaced by all ones, load priority over advance
    step(1'b1, 1'b1, 20'h00000, "R6 zero seed");
    chk("R6 zero seed state", 32'(state_o), 32'hFFFFF);
    step(1'b1, 1'b1, 20'hABCDE, "R6 priority");
    chk("R6 priority state", 32'(state_o), 32'hABCDE);
    for (int i = 0; i < 2000; i++) step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 63) == 0),
                                        20'($urandom), "R1 R2 R6 mixed");

    // R5: reset in mid-run
    rst = 1'b1; adv_i = 1'b1;
    @(negedge clk);
    rst = 1'b0; adv_i = 1'b0;
    model = 20'hFFFFF;
    chk("R5 mid reset state", 32'(state_o), 32'hFFFFF);
    chk("R5 mid reset bit", 32'(bit_o), 32'd1);
    for (int i = 0; i < 50; i++) step(1'b1, 1'b0, '0, "R1 R2 after reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule